// File: doc/BRIEF.md
# Boot-Block Write-Protection and Reset Gate

This block sits in front of the program/erase engine of a dual-bank flash array. It decides whether each program or erase request is carried out or dropped without effect. The decision uses a protection bit held for each block, a three-level write-protect input (low, high or boosted program voltage), a three-level reset input (low, high or identification voltage), and a configuration bit that places the boot blocks at the top or the bottom of the array.

A request that is not dropped starts a busy period, which stands in for the program or erase algorithm. While that period runs, the ready/busy line is held low. A dropped request causes no busy period and sets a sticky rejection flag. The block also qualifies hardware resets. A reset-low pulse shorter than a minimum length has no effect. A reset held long enough aborts any operation in progress and clears the flag, and the bus then stays blocked for a recovery delay after reset returns high. A boosted write-protect level puts the block into unlock-bypass mode.

Top module: `bbwp_gate`

## Requirements
- R1: When the request is accepted, a request to a block whose protection bit is 0 starts a busy period. `busy` and `rb_low` rise one cycle after the request and stay high for PROG_CYC cycles for a program (`req_erase`=0) or ERASE_CYC cycles for an erase (`req_erase`=1).
- R2: While `wp_level` is low (2'd0), a request to one of the two outermost blocks is rejected. This holds even when `rst_level` is at identification level (2'd2). The outermost blocks are NBLK-2 and NBLK-1 when `boot_top`=1, and 0 and 1 when `boot_top`=0.
- R3: With `wp_level` high (2'd1) or boosted (2'd2), the outermost blocks follow their own protection bits like any other block.
- R4: While `rst_level` is at identification level (2'd2), the protection bits are ignored. Only the R2 override still applies.
- R5: A rejected request starts no busy period. It sets `reject_flag` one cycle later, and the flag stays set until the synchronous reset or a qualified hardware reset.
- R6: `bypass` equals, one cycle later, whether `wp_level` is boosted (2'd2). It clears once the level returns to high or low.
- R7: A reset-low (`rst_level`=2'd0) pulse of fewer than MIN_LOW cycles does not abort a running operation and does not clear `reject_flag`.
- R8: Holding reset low for MIN_LOW cycles or more aborts any busy period and clears `reject_flag`. After reset leaves low, `bus_ok` stays 0 for RECOV cycles and then becomes 1.
- R9: A request is accepted only when `bus_ok`=1, `busy`=0 and `rst_level` is not low. Any other request has no effect on `busy` or `reject_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_level | input | 2 | Write-protect level: 0 low, 1 high, 2 boosted |
| rst_level | input | 2 | Reset pin level: 0 low, 1 high, 2 identification |
| boot_top | input | 1 | 1: boot blocks at top indices, 0: at bottom |
| prot_bits | input | NBLK | Stored protection bit per block |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | $clog2(NBLK) | Target block index |
| req_erase | input | 1 | 1 erase, 0 program |
| busy | output | 1 | Operation in progress |
| rb_low | output | 1 | Ready/busy line driven low (else released) |
| bus_ok | output | 1 | Bus operations allowed |
| bypass | output | 1 | Unlock-bypass mode active |
| reject_flag | output | 1 | Sticky: a request was rejected |

## Verification
Two situations are hard to reach from the ports. The first is the combination in which the identification-level reset and the low write-protect pull in opposite directions on the same outer block. The bench sets both levels together on the same request, in both boot placements. The second is telling a short reset pulse apart from a qualified one while an erase is running. The bench starts a long erase, drops reset for one cycle less than the minimum, and confirms that the busy period survives. It then drops reset for longer than the minimum and confirms that the operation is aborted, that the flag is cleared and that the recovery window holds off a new request.

// File: rtl/bbwp_pkg.sv
package bbwp_pkg;
  typedef enum logic [1:0] {
    LVL_LOW   = 2'd0,
    LVL_HIGH  = 2'd1,
    LVL_BOOST = 2'd2
  } lvl_t;
endpackage

// File: rtl/bbwp_prot_decode.sv
module bbwp_prot_decode
  import bbwp_pkg::*;
#(
  parameter int NBLK = 8,
  localparam int BW = $clog2(NBLK)
) (
  input  logic [1:0]      wp_level,
  input  logic [1:0]      rst_level,
  input  logic            boot_top,
  input  logic [NBLK-1:0] prot_bits,
  input  logic [BW-1:0]   blk,
  output logic            locked
);
  logic [NBLK-1:0] lock_vec;
  logic wp_low, temp_unprot;

  assign wp_low      = (wp_level == LVL_LOW);
  assign temp_unprot = (rst_level == LVL_BOOST);

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam bit EDGE_TOP = (i >= NBLK - 2);
    localparam bit EDGE_BOT = (i < 2);
    logic edge_blk;
    assign edge_blk    = boot_top ? EDGE_TOP : EDGE_BOT;
    assign lock_vec[i] = (prot_bits[i] && !temp_unprot) || (wp_low && edge_blk);
  end

  assign locked = lock_vec[blk];
endmodule

// File: rtl/bbwp_rst_seq.sv
module bbwp_rst_seq
  import bbwp_pkg::*;
#(
  parameter int MIN_LOW = 4,
  parameter int RECOV   = 6,
  localparam int LW = $clog2(MIN_LOW + 1),
  localparam int RW = $clog2(RECOV + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rst_level,
  output logic       hw_reset,
  output logic       bus_ok
);
  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic pin_low;

  assign pin_low = (rst_level == LVL_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      rec_cnt  <= '0;
      hw_reset <= 1'b0;
      bus_ok   <= 1'b1;
    end else if (pin_low) begin
      bus_ok <= 1'b0;
      if (low_cnt == LW'(MIN_LOW - 1)) hw_reset <= 1'b1;
      else low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
      if (hw_reset) begin
        hw_reset <= 1'b0;
        rec_cnt  <= RW'(RECOV);
        bus_ok   <= 1'b0;
      end else if (rec_cnt != '0) begin
        rec_cnt <= rec_cnt - 1'b1;
        bus_ok  <= 1'b0;
      end else begin
        bus_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bbwp_op_timer.sv
module bbwp_op_timer #(
  parameter int PROG_CYC  = 5,
  parameter int ERASE_CYC = 12,
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic start,
  input  logic erase,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/bbwp_gate.sv
module bbwp_gate
  import bbwp_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int MIN_LOW   = 4,
  parameter int RECOV     = 6,
  parameter int PROG_CYC  = 5,
  parameter int ERASE_CYC = 12,
  localparam int BW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      wp_level,
  input  logic [1:0]      rst_level,
  input  logic            boot_top,
  input  logic [NBLK-1:0] prot_bits,
  input  logic            req_valid,
  input  logic [BW-1:0]   req_blk,
  input  logic            req_erase,
  output logic            busy,
  output logic            rb_low,
  output logic            bus_ok,
  output logic            bypass,
  output logic            reject_flag
);
  logic locked, hw_reset, take, start;

  bbwp_prot_decode #(.NBLK(NBLK)) u_dec (
    .wp_level (wp_level),
    .rst_level(rst_level),
    .boot_top (boot_top),
    .prot_bits(prot_bits),
    .blk      (req_blk),
    .locked   (locked)
  );

  bbwp_rst_seq #(.MIN_LOW(MIN_LOW), .RECOV(RECOV)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rst_level(rst_level),
    .hw_reset (hw_reset),
    .bus_ok   (bus_ok)
  );

  assign take  = req_valid && bus_ok && !busy && (rst_level != LVL_LOW);
  assign start = take && !locked;

  bbwp_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .abort(hw_reset),
    .start(start),
    .erase(req_erase),
    .busy (busy)
  );

  assign rb_low = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      bypass      <= 1'b0;
      reject_flag <= 1'b0;
    end else begin
      bypass <= (wp_level == LVL_BOOST);
      if (hw_reset) reject_flag <= 1'b0;
      else if (take && locked) reject_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/bbwp_gate_chk.sv
module bbwp_gate_chk #(
  parameter int NBLK = 8,
  localparam int BW = $clog2(NBLK)
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      wp_level,
  input logic [1:0]      rst_level,
  input logic            boot_top,
  input logic            req_valid,
  input logic [BW-1:0]   req_blk,
  input logic            busy,
  input logic            bus_ok,
  input logic            bypass,
  input logic            reject_flag
);
  logic edge_hit;
  assign edge_hit = boot_top ? (int'(req_blk) >= NBLK - 2) : (int'(req_blk) < 2);

  assert_edge_override_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bus_ok && !busy && rst_level != 2'd0 && wp_level == 2'd0 && edge_hit)
      |=> (!busy && reject_flag));

  assert_bypass_follow_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bypass == ($past(wp_level) == 2'd2)));

  assert_low_blocks_bus_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_level == 2'd0) |=> !bus_ok);

  assert_start_needs_bus_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(bus_ok) && $past(req_valid)));

  assert_reject_no_busy_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(reject_flag) && !$past(busy)) |-> !busy);
endmodule

bind bbwp_gate bbwp_gate_chk #(.NBLK(NBLK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wp_level   (wp_level),
  .rst_level  (rst_level),
  .boot_top   (boot_top),
  .req_valid  (req_valid),
  .req_blk    (req_blk),
  .busy       (busy),
  .bus_ok     (bus_ok),
  .bypass     (bypass),
  .reject_flag(reject_flag)
);

// File: tb/bbwp_gate_test.sv
module bbwp_gate_test;
  localparam int NBLK = 8, MIN_LOW = 4, RECOV = 6, PROG_CYC = 5, ERASE_CYC = 12;
  localparam int NV = 13;
  // fields: wp[17:16] rl[15:14] top[13] prot[12:5] blk[4:2] erase[1] expect_reject[0]
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 2'd1, 1'b1, 8'h00, 3'd7, 1'b0, 1'b0},
    {2'd0, 2'd1, 1'b1, 8'h00, 3'd7, 1'b0, 1'b1},
    {2'd0, 2'd1, 1'b1, 8'h00, 3'd6, 1'b1, 1'b1},
    {2'd0, 2'd1, 1'b1, 8'h00, 3'd5, 1'b0, 1'b0},
    {2'd0, 2'd1, 1'b0, 8'h00, 3'd0, 1'b0, 1'b1},
    {2'd0, 2'd1, 1'b0, 8'h00, 3'd7, 1'b0, 1'b0},
    {2'd1, 2'd1, 1'b1, 8'h08, 3'd3, 1'b0, 1'b1},
    {2'd1, 2'd2, 1'b1, 8'h08, 3'd3, 1'b0, 1'b0},
    {2'd0, 2'd2, 1'b1, 8'h80, 3'd7, 1'b0, 1'b1},
    {2'd1, 2'd2, 1'b1, 8'h80, 3'd7, 1'b0, 1'b0},
    {2'd2, 2'd1, 1'b1, 8'h04, 3'd2, 1'b0, 1'b1},
    {2'd2, 2'd1, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0},
    {2'd1, 2'd1, 1'b1, 8'h80, 3'd7, 1'b0, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic [1:0] wp_level = 2'd1, rst_level = 2'd1;
  logic boot_top = 1;
  logic [NBLK-1:0] prot_bits = '0;
  logic req_valid = 0, req_erase = 0;
  logic [2:0] req_blk = '0;
  logic busy, rb_low, bus_ok, bypass, reject_flag;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  bbwp_gate #(.NBLK(NBLK), .MIN_LOW(MIN_LOW), .RECOV(RECOV),
              .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) uut (
    .clk(clk), .rst(rst), .wp_level(wp_level), .rst_level(rst_level),
    .boot_top(boot_top), .prot_bits(prot_bits), .req_valid(req_valid),
    .req_blk(req_blk), .req_erase(req_erase), .busy(busy), .rb_low(rb_low),
    .bus_ok(bus_ok), .bypass(bypass), .reject_flag(reject_flag));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_reset();
    rst = 1; step(1); rst = 0;
  endtask

  task automatic pulse_req(logic [2:0] b, logic e);
    req_blk = b; req_erase = e; req_valid = 1; step(1); req_valid = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40 && busy; k++) step(1);
  endtask

  task automatic measure_busy(logic e, int exp_len, string tag);
    int n = 0;
    pulse_req(3'd4, e);
    while (busy && n < 40) begin
      check(tag, rb_low, 1);
      n++; step(1);
    end
    check(tag, n, exp_len);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    step(2);
    rst = 0;
    step(1);
    // reset state
    check("R5 reset flag", reject_flag, 0);
    check("R1 reset busy", busy, 0);
    check("R8 reset bus_ok", bus_ok, 1);
    check("R6 reset bypass", bypass, 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      sync_reset();
      wp_level  = VEC[v][17:16];
      rst_level = VEC[v][15:14];
      boot_top  = VEC[v][13];
      prot_bits = VEC[v][12:5];
      step(1);
      pulse_req(VEC[v][4:2], VEC[v][1]);
      check($sformatf("R2/R3/R4/R5 vec%0d reject", v), reject_flag, VEC[v][0]);
      check($sformatf("R1/R5 vec%0d busy", v), busy, !VEC[v][0]);
      wait_idle();
    end

    // R1 durations
    sync_reset();
    wp_level = 2'd1; rst_level = 2'd1; prot_bits = '0; step(1);
    measure_busy(1'b0, PROG_CYC, "R1 program length");
    measure_busy(1'b1, ERASE_CYC, "R1 erase length");

    // R6 bypass entry and exit
    wp_level = 2'd2; step(2);
    check("R6 bypass on", bypass, 1);
    wp_level = 2'd1; step(2);
    check("R6 bypass off high", bypass, 0);
    wp_level = 2'd2; step(2);
    wp_level = 2'd0; step(2);
    check("R6 bypass off low", bypass, 0);

    // R9 request while busy ignored (protected target)
    sync_reset();
    wp_level = 2'd1; prot_bits = 8'h02; step(1);
    pulse_req(3'd4, 1'b1);
    pulse_req(3'd1, 1'b0);
    check("R9 busy request no flag", reject_flag, 0);
    // R7 short reset pulse during erase, after setting flag
    wait_idle();
    pulse_req(3'd1, 1'b0);
    check("R7 flag set", reject_flag, 1);
    pulse_req(3'd4, 1'b1);
    rst_level = 2'd0; step(MIN_LOW - 1); rst_level = 2'd1; step(2);
    check("R7 busy survives", busy, 1);
    check("R7 flag survives", reject_flag, 1);
    // R8 qualified reset
    rst_level = 2'd0; step(MIN_LOW + 2);
    check("R8 busy aborted", busy, 0);
    check("R8 flag cleared", reject_flag, 0);
    rst_level = 2'd1; step(1);
    pulse_req(3'd4, 1'b0);
    check("R9 recovery request ignored", busy, 0);
    step(RECOV - 3);
    check("R8 bus blocked in recovery", bus_ok, 0);
    step(5);
    check("R8 bus ok after recovery", bus_ok, 1);
    pulse_req(3'd4, 1'b0);
    check("R1 accepted after recovery", busy, 1);
    wait_idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule